// File: doc/BRIEF.md
# Embedded Operation Status Poller

This block forms the status byte that a host sees when it reads a flash bank during an embedded program or erase. The final write of a command sequence starts the operation. The program and erase engine is stood in for by a busy timer. While that timer runs, reads return polling information instead of array data:

- an address-qualified data-polling bit (bit 7)
- a toggle bit that flips on each read (bit 6)
- a timeout flag (bit 5)
- an erase-in-progress flag (bit 3)
- an erase toggle bit (bit 2)

A ready/busy output goes low for the whole operation.

When the bank is idle, a read returns the datum that the last completed operation left behind. This stands in for the array, which is not modelled. A program aimed at a locked sector keeps the polling active for a short fixed window only, and then the bank returns to read mode with nothing written. If the engine stays busy past a set number of cycles, the block raises the timeout flag. It then freezes the status until reset.

Top module: `flashStatusPoll`

## Requirements
- R1: After reset, `readyBusy` is 1 and a read returns 8'hFF.
- R2: A `cmdWrite` while ready starts an operation. `readyBusy` is 0 from the next cycle for exactly PROG_CYCLES cycles for an unlocked program, then returns to 1.
- R3: While a program runs, a read at the program address returns the complement of datum bit 7 on bit 7. Once the program is done, reads return the programmed datum, so bit 7 is its true value.
- R4: While a program runs, a read at any other address returns 1 on bit 7.
- R5: While busy, bit 6 reads 0 on the first read after the command and flips on each later read. During a normal program, bits 5 down to 0 read 0.
- R6: A program with `sectorLocked` high keeps `readyBusy` low for PROT_CYCLES cycles, with bit 7 polling as in R3. Afterwards reads return the earlier datum unchanged.
- R7: An erase (`cmdErase` high) keeps `readyBusy` low for ERASE_CYCLES cycles. During it, bit 7 reads 0 at every address, bit 3 reads 1, and bit 2 flips on each read starting at 0. Afterwards reads return 8'hFF.
- R8: A program issued with `eraseSuspended` high polls bit 7 exactly as in R3 and keeps bit 3 at 0, while bit 2 flips on each read starting at 0. Without suspend, bit 2 stays 0.
- R9: If `holdBusy` keeps the engine busy for LIMIT cycles, bit 5 becomes 1 and `readyBusy` stays 0. Bits 6, 2 and 7 stop changing, and this lasts until reset, even after `holdBusy` drops.
- R10: A `cmdWrite` while busy is ignored. The running operation keeps its address and datum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWrite | input | 1 | Final write of a program/erase command (one-cycle strobe) |
| cmdErase | input | 1 | 1 selects erase, 0 selects program |
| cmdAddr | input | ADDR_W | Program target address |
| cmdData | input | 8 | Datum to program |
| sectorLocked | input | 1 | Target sector is protected |
| eraseSuspended | input | 1 | Bank is in erase suspend |
| holdBusy | input | 1 | Engine cannot finish (models a stuck operation) |
| rdStrobe | input | 1 | Host read this cycle |
| rdAddr | input | ADDR_W | Host read address |
| statusOut | output | 8 | Read data: status while busy, stored datum while idle |
| readyBusy | output | 1 | 1 = ready, 0 = embedded operation running |

## Verification
A captured address or datum that is wrong appears on bit 7 on the first status read, because the complement polarity or the address qualification flips. A wrong timer or state appears as a `readyBusy` width that differs by whole cycles from PROG_CYCLES, PROT_CYCLES or ERASE_CYCLES, or as a missing timeout flag after LIMIT cycles. Toggle flops that are wrong show up within two consecutive reads. A commit that is wrong or missing shows on the first idle read afterwards.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STUCK = 2'd2
  } pollState_t;

  typedef struct packed {
    logic capture;  // latch address/datum, clear toggles
    logic commit;   // write result into read-mode datum
    logic busy;     // operation running or stuck
    logic erase;    // running operation is an erase
    logic failed;   // timeout reached, status frozen
  } pollCtl_t;

endpackage

// File: rtl/fspCtrl.sv
module fspCtrl
  import fsp_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 32,
  parameter int PROT_CYCLES  = 6,
  parameter int LIMIT        = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdWrite,
  input  logic     cmdErase,
  input  logic     sectorLocked,
  input  logic     holdBusy,
  output pollCtl_t ctl
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROT_LAST  = CNT_W'(PROT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(LIMIT - 1);

  pollState_t       state;
  logic [CNT_W-1:0] cnt;
  logic             isErase;
  logic             isProt;
  logic [CNT_W-1:0] lastCnt;
  logic             atEnd;
  logic             finish;
  logic             timeout;
  logic             start;

  always_comb begin
    if (isErase)     lastCnt = ERASE_LAST;
    else if (isProt) lastCnt = PROT_LAST;
    else             lastCnt = PROG_LAST;
  end

  assign start   = cmdWrite && (state == ST_IDLE);
  assign atEnd   = (cnt == lastCnt);
  assign finish  = (state == ST_RUN) && atEnd && (!holdBusy || isProt);
  assign timeout = (state == ST_RUN) && !finish && (cnt == LIMIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isErase <= 1'b0;
      isProt  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            cnt     <= '0;
            isErase <= cmdErase;
            isProt  <= sectorLocked && !cmdErase;
          end
        end
        ST_RUN: begin
          if (finish)       state <= ST_IDLE;
          else if (timeout) state <= ST_STUCK;
          else              cnt   <= cnt + 1'b1;
        end
        ST_STUCK: state <= ST_STUCK;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture = start;
    ctl.commit  = finish && !isProt;
    ctl.busy    = (state != ST_IDLE);
    ctl.erase   = isErase;
    ctl.failed  = (state == ST_STUCK);
  end

  AST_STUCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STUCK) |=> (state == ST_STUCK)); // R9
  AST_CNT_IN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (cnt <= LIMIT_LAST)); // R9
  AST_CAPTURE_STARTS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (state == ST_RUN) && (cnt == '0)); // R10
  AST_PROT_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && isProt && cnt == PROT_LAST) |=> (state == ST_IDLE)); // R6

endmodule

// File: rtl/fspData.sv
module fspData
  import fsp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollCtl_t          ctl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              eraseSuspended,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        statusOut
);

  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic [7:0]        memData;
  logic              tgl6;
  logic              tgl2;
  logic              tglActive;
  logic              eraseTgl;
  logic              pollBit;

  assign tglActive = rdStrobe && ctl.busy && !ctl.failed;
  assign eraseTgl  = ctl.erase || eraseSuspended;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAddr  <= '0;
      opData  <= 8'hFF;
      memData <= 8'hFF;
      tgl6    <= 1'b0;
      tgl2    <= 1'b0;
    end else begin
      if (ctl.capture) begin
        opAddr <= cmdAddr;
        opData <= cmdData;
        tgl6   <= 1'b0;
        tgl2   <= 1'b0;
      end else if (tglActive) begin
        tgl6 <= ~tgl6;
        if (eraseTgl) tgl2 <= ~tgl2;
      end
      if (ctl.commit) memData <= ctl.erase ? 8'hFF : opData;
    end
  end

  always_comb begin
    if (ctl.erase)              pollBit = 1'b0;
    else if (rdAddr == opAddr)  pollBit = ~opData[7];
    else                        pollBit = 1'b1;
  end

  always_comb begin
    if (!ctl.busy) statusOut = memData;
    else statusOut = {pollBit, tgl6, ctl.failed, 1'b0, ctl.erase,
                      eraseTgl ? tgl2 : 1'b0, 2'b00};
  end

  AST_TGL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.failed && !ctl.capture) |=> ($stable(tgl6) && $stable(tgl2))); // R9
  AST_MEM_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(memData)); // R6
  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (tglActive && !ctl.capture) |=> (tgl6 != $past(tgl6))); // R5

endmodule

// File: rtl/flashStatusPoll.sv
module flashStatusPoll
  import fsp_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 32,
  parameter int PROT_CYCLES  = 6,
  parameter int LIMIT        = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic              cmdErase,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              sectorLocked,
  input  logic              eraseSuspended,
  input  logic              holdBusy,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        statusOut,
  output logic              readyBusy
);

  pollCtl_t ctl;

  fspCtrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .PROT_CYCLES (PROT_CYCLES),
    .LIMIT       (LIMIT)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdWrite    (cmdWrite),
    .cmdErase    (cmdErase),
    .sectorLocked(sectorLocked),
    .holdBusy    (holdBusy),
    .ctl         (ctl)
  );

  fspData #(.ADDR_W(ADDR_W)) i_data (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .cmdAddr       (cmdAddr),
    .cmdData       (cmdData),
    .eraseSuspended(eraseSuspended),
    .rdStrobe      (rdStrobe),
    .rdAddr        (rdAddr),
    .statusOut     (statusOut)
  );

  assign readyBusy = !ctl.busy;

  AST_RDY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && readyBusy) |=> !readyBusy); // R2
  AST_TIMEOUT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.failed |-> (!readyBusy && statusOut[5])); // R9

endmodule

// File: tb/test_flashStatusPoll.sv
module test_flashStatusPoll;

  localparam int ADDR_W = 12;
  localparam int PROG   = 16;
  localparam int ERASE  = 32;
  localparam int PROT   = 6;
  localparam int LIMIT  = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdWrite = 1'b0;
  logic              cmdErase = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0]        cmdData = '0;
  logic              sectorLocked = 1'b0;
  logic              eraseSuspended = 1'b0;
  logic              holdBusy = 1'b0;
  logic              rdStrobe = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        statusOut;
  logic              readyBusy;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flashStatusPoll #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE),
    .PROT_CYCLES(PROT), .LIMIT(LIMIT)
  ) i_flashStatusPoll (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdErase(cmdErase),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .sectorLocked(sectorLocked),
    .eraseSuspended(eraseSuspended), .holdBusy(holdBusy),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .statusOut(statusOut),
    .readyBusy(readyBusy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Starts at a negedge, returns at the negedge after the capturing edge.
  task automatic issue(input logic erase, input logic [ADDR_W-1:0] a,
                       input logic [7:0] d, input logic locked);
    cmdWrite = 1'b1; cmdErase = erase; cmdAddr = a; cmdData = d;
    sectorLocked = locked;
    @(negedge clk);
    cmdWrite = 1'b0; cmdErase = 1'b0; sectorLocked = 1'b0;
  endtask

  // One read: sampled at this negedge, strobe seen at next posedge.
  task automatic readAt(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    rdAddr = a; rdStrobe = 1'b1;
    #1 v = statusOut;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  // Counts busy negedges from now until ready.
  task automatic busyCycles(output int n);
    n = 0;
    while (!readyBusy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    doReset();
    check(readyBusy === 1'b1, "R1 ready after reset", readyBusy, 1);
    readAt(12'h000, v);
    check(v === 8'hFF, "R1 read after reset", v, 8'hFF);
  endtask

  task automatic testProgramLength();
    logic [7:0] v;
    int n;
    issue(1'b0, 12'h010, 8'h5A, 1'b0);
    busyCycles(n);
    check(n == PROG, "R2 program busy width", n, PROG);
    readAt(12'h010, v);
    check(v === 8'h5A, "R3 datum after program", v, 8'h5A);
  endtask

  task automatic testPolling();
    logic [7:0] v;
    int n;
    issue(1'b0, 12'h123, 8'hA5, 1'b0);
    readAt(12'h123, v);
    check(v[7] === 1'b0, "R3 dq7 complement at program address", v[7], 0);
    check(v[6] === 1'b0, "R5 dq6 first read", v[6], 0);
    check(v[5:0] === 6'h00, "R5 low bits zero during program", v[5:0], 0);
    readAt(12'h124, v);
    check(v[7] === 1'b1, "R4 dq7 at other address", v[7], 1);
    check(v[6] === 1'b1, "R5 dq6 second read", v[6], 1);
    issue(1'b0, 12'h200, 8'h00, 1'b0);  // ignored while busy
    readAt(12'h123, v);
    check(v[7] === 1'b0, "R10 address and datum kept", v[7], 0);
    check(v[6] === 1'b0, "R5 dq6 third read", v[6], 0);
    busyCycles(n);
    check(n == PROG - 4, "R10 busy width unchanged", n, PROG - 4);
    readAt(12'h123, v);
    check(v === 8'hA5, "R3 true datum after completion", v, 8'hA5);
  endtask

  task automatic testProtected();
    logic [7:0] v;
    int n;
    issue(1'b0, 12'h040, 8'hC3, 1'b1);
    readAt(12'h040, v);
    check(v[7] === 1'b0, "R6 dq7 polling in locked window", v[7], 0);
    busyCycles(n);
    check(n == PROT - 1, "R6 locked window width", n, PROT - 1);
    readAt(12'h040, v);
    check(v === 8'hA5, "R6 datum unchanged after locked program", v, 8'hA5);
  endtask

  task automatic testErase();
    logic [7:0] v;
    int n;
    issue(1'b1, 12'h000, 8'h00, 1'b0);
    readAt(12'h000, v);
    check(v[7] === 1'b0 && v[3] === 1'b1, "R7 erase dq7 0 dq3 1", {v[7], v[3]}, 1);
    check(v[2] === 1'b0, "R7 dq2 first read", v[2], 0);
    readAt(12'h7FF, v);
    check(v[7] === 1'b0, "R7 dq7 0 at other address", v[7], 0);
    check(v[2] === 1'b1, "R7 dq2 second read", v[2], 1);
    busyCycles(n);
    check(n == ERASE - 2, "R7 erase busy width", n, ERASE - 2);
    readAt(12'h000, v);
    check(v === 8'hFF, "R7 erased datum", v, 8'hFF);
  endtask

  task automatic testSuspendProgram();
    logic [7:0] v;
    int n;
    eraseSuspended = 1'b1;
    issue(1'b0, 12'h055, 8'h81, 1'b0);
    readAt(12'h055, v);
    check(v[7] === 1'b0 && v[3] === 1'b0, "R8 dq7 complement, dq3 0", {v[7], v[3]}, 0);
    check(v[2] === 1'b0, "R8 dq2 first read", v[2], 0);
    readAt(12'h055, v);
    check(v[2] === 1'b1, "R8 dq2 second read", v[2], 1);
    busyCycles(n);
    eraseSuspended = 1'b0;
    readAt(12'h055, v);
    check(v === 8'h81, "R8 datum after suspended program", v, 8'h81);
  endtask

  task automatic testTimeout();
    logic [7:0] v;
    logic [7:0] w;
    holdBusy = 1'b1;
    issue(1'b0, 12'h0AA, 8'h80, 1'b0);
    repeat (LIMIT + 4) @(negedge clk);
    check(readyBusy === 1'b0, "R9 still busy after limit", readyBusy, 0);
    readAt(12'h0AA, v);
    check(v[5] === 1'b1 && v[7] === 1'b0, "R9 dq5 set, dq7 held", {v[7], v[5]}, 1);
    holdBusy = 1'b0;
    issue(1'b0, 12'h001, 8'h00, 1'b0);
    repeat (5) @(negedge clk);
    readAt(12'h0AA, w);
    check(w === v, "R9 status frozen", w, v);
    check(readyBusy === 1'b0, "R9 busy until reset", readyBusy, 0);
    doReset();
    check(readyBusy === 1'b1, "R1 ready after reset from timeout", readyBusy, 1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testProgramLength();
    testPolling();
    testProtected();
    testErase();
    testSuspendProgram();
    testTimeout();
    finishRun();
  end

endmodule